// File: doc/BRIEF.md
# Vector Condition-Field Result Sequencer

This block steps through the elements of a vectorised condition-register operation, one element per clock, from element 0 up to the vector length. Each element's result is either a 4-bit condition field or a single condition bit, depending on whether the operation targets whole fields or single bits. The block applies the predicate mask and its zeroing option. It picks the bit to test and compares it against an invert flag. It then issues a write to the condition register, suppresses the write, or cuts the vector length short.

A start pulse captures the mode word, the vector length, the predicate mask and the whole set of per-element results. A write strobe then carries the element index and the data to store. A one-cycle done pulse carries the final vector length. The reserved mode is flagged as illegal.

Top module: `cr_vec_seq`

## Requirements
- R1: After reset `wr_o`, `done_o`, `illegal_o`, `busy_o` are 0 and `vl_o` is 0. With start sampled at clock edge t, element i is judged in the cycle after edge t+i, and its write appears after edge t+1+i on `wr_o`, `wr_idx_o` = i and `wr_data_o`. The elements are taken one per cycle in order.
- R2: Mode fields are as follows. The selector is `mode_i[20:19]`, read as a number: 0 normal, 1 fail-first, 2 reserved, 3 predicate-result. The invert flag is `mode_i[21]` and the bit select is `mode_i[23:22]`. `mode_i[5]` is the substitute value in predicate-result mode and the include-failing flag in fail-first mode. The zeroing flag is `mode_i[23]` in normal mode and in single-bit predicate-result mode, and `mode_i[4]` in fail-first mode and in field predicate-result mode.
- R3: In normal mode every unmasked element writes its result and no test is made.
- R4: A masked element (`mask_i[i]`=0) with the zeroing flag clear is skipped. It is not written, it is not tested, and it never truncates.
- R5: A masked element with the zeroing flag set uses a substitute value. The substitute bit is `mode_i[5]` in predicate-result mode and 0 otherwise. In field mode it fills all four bits. In single-bit mode it goes to bit 0 and bits 3:1 are 0.
- R6: In field mode (`bit_op_i`=0) the tested bit is result bit `mode_i[23:22]`. In single-bit mode (`bit_op_i`=1) the result is bit 0 of the element's nibble, which is both tested and written as data `{3'b000, bit}`.
- R7: In predicate-result mode an element, computed or substituted, is written only when its tested bit equals the invert flag.
- R8: In fail-first mode the first element whose tested bit differs from the invert flag ends the run. Done is raised with that element's write slot, and no later element is written.
- R9: On a fail-first truncation at element f, `vl_o` is f+1 and element f is written when `mode_i[5]`=1. When `mode_i[5]`=0, `vl_o` is f and element f is not written.
- R10: Without truncation, done pulses for one cycle together with the last element's slot, with `vl_o` equal to the vector length. The length is clamped to MAX_VL. A length of 0 gives done after edge t with `vl_o`=0 and no writes.
- R11: Selector value 2 gives `illegal_o`=1 and `done_o`=1 after edge t, with `vl_o`=0 and no writes.
- R12: A start pulse while busy is ignored and does not alter the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a run |
| mode_i | input | MODE_W | Mode word |
| bit_op_i | input | 1 | 1: single-bit results, 0: 4-bit field results |
| vl_i | input | VL_W | Vector length |
| mask_i | input | MAX_VL | Predicate mask, bit i for element i |
| res_i | input | MAX_VL*4 | Results, element i at bits 4i+3:4i |
| busy_o | output | 1 | Run in progress |
| wr_o | output | 1 | Condition-register write strobe |
| wr_idx_o | output | IDX_W | Element index of the write |
| wr_data_o | output | 4 | Write data |
| done_o | output | 1 | One-cycle end-of-run pulse |
| vl_o | output | VL_W | Final vector length, valid with done |
| illegal_o | output | 1 | Reserved mode flagged, with done |

## Verification
Every result is registered once. Element i's write slot is due one cycle after the start edge plus i, and a done pulse shares the slot of the element that ends the run. A reserved mode or a zero length produces its done in the first slot after the start edge. The bench model turns each run into a queue with one expected entry per cycle, beginning at the falling edge after the start edge. It compares the queue against the ports on every falling edge, and it also checks two idle cycles after each run so that a late or repeated strobe is caught.

// File: rtl/cr_seq_pkg.sv
package cr_seq_pkg;
  localparam int FIELD_W = 4;
  localparam int CRB_W   = $clog2(FIELD_W);

  typedef enum logic [1:0] {
    SEL_NORM   = 2'd0,
    SEL_FFIRST = 2'd1,
    SEL_RSVD   = 2'd2,
    SEL_PRED   = 2'd3
  } mode_sel_e;

  typedef struct packed {
    mode_sel_e        sel;
    logic             bit_op;
    logic             inv;
    logic [CRB_W-1:0] crbit;
    logic             zero;
    logic             snz;
    logic             vli;
  } elem_cfg_t;
endpackage

// File: rtl/cr_seq_decode.sv
module cr_seq_decode
  import cr_seq_pkg::*;
#(
  parameter int MODE_W = 24
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              bit_op_i,
  output elem_cfg_t         cfg_o
);
  localparam int SEL_LO = 19;
  localparam int INV_B  = 21;
  localparam int CRB_LO = 22;
  localparam int ZLO_B  = 4;
  localparam int AUX_B  = 5;
  localparam int ZHI_B  = 23;

  mode_sel_e sel;
  logic      unused_mode;

  assign sel         = mode_sel_e'(mode_i[SEL_LO+1:SEL_LO]);
  assign unused_mode = ^{mode_i[ZLO_B-1:0], mode_i[SEL_LO-1:AUX_B+1]};

  always_comb begin
    cfg_o        = '0;
    cfg_o.sel    = sel;
    cfg_o.bit_op = bit_op_i;
    cfg_o.inv    = mode_i[INV_B];
    cfg_o.crbit  = mode_i[CRB_LO +: CRB_W];
    cfg_o.snz    = (sel == SEL_PRED) ? mode_i[AUX_B] : 1'b0;
    cfg_o.vli    = (sel == SEL_FFIRST) ? mode_i[AUX_B] : 1'b0;
    unique case (sel)
      SEL_NORM:   cfg_o.zero = mode_i[ZHI_B];
      SEL_FFIRST: cfg_o.zero = mode_i[ZLO_B];
      SEL_PRED:   cfg_o.zero = bit_op_i ? mode_i[ZHI_B] : mode_i[ZLO_B];
      default:    cfg_o.zero = 1'b0;
    endcase
  end
endmodule

// File: rtl/cr_seq_elem.sv
module cr_seq_elem
  import cr_seq_pkg::*;
(
  input  elem_cfg_t          cfg_i,
  input  logic               mask_i,
  input  logic [FIELD_W-1:0] res_i,
  output logic               wr_o,
  output logic [FIELD_W-1:0] data_o,
  output logic               fail_o
);
  logic [FIELD_W-1:0] fill, comp, val;
  logic               skip, tbit, pass;

  // substitute: full copy in field mode, bit 0 only in single-bit mode
  for (genvar k = 0; k < FIELD_W; k++) begin : g_fill
    if (k == 0) begin : g_lsb
      assign fill[k] = cfg_i.snz;
    end else begin : g_hi
      assign fill[k] = cfg_i.snz & ~cfg_i.bit_op;
    end
  end

  assign comp = cfg_i.bit_op ? {{(FIELD_W-1){1'b0}}, res_i[0]} : res_i;
  assign val  = mask_i ? comp : fill;
  assign skip = ~mask_i & ~cfg_i.zero;
  assign tbit = cfg_i.bit_op ? val[0] : val[cfg_i.crbit];
  assign pass = (tbit == cfg_i.inv);

  always_comb begin
    wr_o   = 1'b0;
    fail_o = 1'b0;
    data_o = val;
    if (!skip) begin
      unique case (cfg_i.sel)
        SEL_NORM:   wr_o = 1'b1;
        SEL_FFIRST: begin
          wr_o   = pass | cfg_i.vli;
          fail_o = ~pass;
        end
        SEL_PRED:   wr_o = pass;
        default:    wr_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    if (!mask_i && wr_o && !cfg_i.bit_op)
      AST_FIELD_FILL: assert ($countones(data_o) == 0 || $countones(data_o) == FIELD_W); // R5
    if (cfg_i.bit_op)
      AST_BIT_DATA: assert (data_o[FIELD_W-1:1] == '0); // R6
  end
endmodule

// File: rtl/cr_seq_walk.sv
module cr_seq_walk
  import cr_seq_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  elem_cfg_t                 cfg_i,
  input  logic [VL_W-1:0]           vl_i,
  input  logic [MAX_VL-1:0]         mask_i,
  input  logic [MAX_VL*FIELD_W-1:0] res_i,
  output elem_cfg_t                 cur_cfg_o,
  output logic                      cur_mask_o,
  output logic [FIELD_W-1:0]        cur_res_o,
  input  logic                      ev_wr_i,
  input  logic [FIELD_W-1:0]        ev_data_i,
  input  logic                      ev_fail_i,
  output logic                      busy_o,
  output logic                      wr_o,
  output logic [IDX_W-1:0]          wr_idx_o,
  output logic [FIELD_W-1:0]        wr_data_o,
  output logic                      done_o,
  output logic [VL_W-1:0]           vl_o,
  output logic                      illegal_o
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic                      busy_q;
  logic [IDX_W-1:0]          idx_q;
  logic [VL_W-1:0]           vl_q, vl_clip, idx_ext;
  elem_cfg_t                 cfg_q;
  logic [MAX_VL-1:0]         mask_q;
  logic [MAX_VL*FIELD_W-1:0] res_q;
  logic                      last;

  assign vl_clip    = (vl_i > VL_CAP) ? VL_CAP : vl_i;
  assign idx_ext    = VL_W'(idx_q);
  assign last       = (idx_ext + 1'b1) == vl_q;
  assign cur_cfg_o  = cfg_q;
  assign cur_mask_o = mask_q[idx_q];
  assign cur_res_o  = res_q[idx_q*FIELD_W +: FIELD_W];
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      vl_q      <= '0;
      cfg_q     <= '0;
      mask_q    <= '0;
      res_q     <= '0;
      wr_o      <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      vl_o      <= '0;
      illegal_o <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          cfg_q  <= cfg_i;
          mask_q <= mask_i;
          res_q  <= res_i;
          vl_q   <= vl_clip;
          idx_q  <= '0;
          if (cfg_i.sel == SEL_RSVD) begin
            done_o    <= 1'b1;
            illegal_o <= 1'b1;
            vl_o      <= '0;
          end else if (vl_clip == '0) begin
            done_o <= 1'b1;
            vl_o   <= '0;
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else begin
        wr_o      <= ev_wr_i;
        wr_idx_o  <= idx_q;
        wr_data_o <= ev_data_i;
        if (ev_fail_i) begin
          done_o <= 1'b1;
          vl_o   <= cfg_q.vli ? idx_ext + 1'b1 : idx_ext;
          busy_q <= 1'b0;
        end else if (last) begin
          done_o <= 1'b1;
          vl_o   <= vl_q;
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) // R1
    busy_q && $past(busy_q) |-> idx_q == IDX_W'($past(idx_q) + 1'b1));
  AST_VL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) // R8
    done_o |-> vl_o <= vl_q);
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) // R10
    done_o |-> !busy_q);
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) // R11
    illegal_o |-> done_o && !wr_o && vl_o == '0);
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni) // R12
    busy_q && start_i |=> $stable(vl_q) && $stable(mask_q) && $stable(res_q));
endmodule

// File: rtl/cr_vec_seq.sv
module cr_vec_seq
  import cr_seq_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int MODE_W = 24,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [MODE_W-1:0]         mode_i,
  input  logic                      bit_op_i,
  input  logic [VL_W-1:0]           vl_i,
  input  logic [MAX_VL-1:0]         mask_i,
  input  logic [MAX_VL*FIELD_W-1:0] res_i,
  output logic                      busy_o,
  output logic                      wr_o,
  output logic [IDX_W-1:0]          wr_idx_o,
  output logic [FIELD_W-1:0]        wr_data_o,
  output logic                      done_o,
  output logic [VL_W-1:0]           vl_o,
  output logic                      illegal_o
);
  elem_cfg_t          dec_cfg, cur_cfg;
  logic               cur_mask, ev_wr, ev_fail;
  logic [FIELD_W-1:0] cur_res, ev_data;

  cr_seq_decode #(.MODE_W(MODE_W)) u_dec (
    .mode_i   (mode_i),
    .bit_op_i (bit_op_i),
    .cfg_o    (dec_cfg)
  );

  cr_seq_walk #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_i      (dec_cfg),
    .vl_i       (vl_i),
    .mask_i     (mask_i),
    .res_i      (res_i),
    .cur_cfg_o  (cur_cfg),
    .cur_mask_o (cur_mask),
    .cur_res_o  (cur_res),
    .ev_wr_i    (ev_wr),
    .ev_data_i  (ev_data),
    .ev_fail_i  (ev_fail),
    .busy_o     (busy_o),
    .wr_o       (wr_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .vl_o       (vl_o),
    .illegal_o  (illegal_o)
  );

  cr_seq_elem u_elem (
    .cfg_i  (cur_cfg),
    .mask_i (cur_mask),
    .res_i  (cur_res),
    .wr_o   (ev_wr),
    .data_o (ev_data),
    .fail_o (ev_fail)
  );
endmodule

// File: tb/tb_cr_vec_seq.sv
module tb_cr_vec_seq;
  localparam int MAX_VL = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] mode_i = '0;
  logic        bit_op_i = 1'b0;
  logic [4:0]  vl_i = '0;
  logic [15:0] mask_i = '0;
  logic [63:0] res_i = '0;
  logic        busy_o, wr_o, done_o, illegal_o;
  logic [3:0]  wr_idx_o, wr_data_o;
  logic [4:0]  vl_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic       wr;
    int         idx;
    logic [3:0] data;
    logic       done;
    int         vl;
    logic       ill;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  cr_vec_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .bit_op_i(bit_op_i), .vl_i(vl_i), .mask_i(mask_i), .res_i(res_i),
    .busy_o(busy_o), .wr_o(wr_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .vl_o(vl_o), .illegal_o(illegal_o)
  );

  function automatic logic [23:0] mk(int sel, bit inv, int crbit, bit zlo, bit aux, bit zhi);
    logic [23:0] m = '0;
    m[20:19] = 2'(sel);
    m[21]    = inv;
    m[23:22] = 2'(crbit);
    m[4]     = zlo;
    m[5]     = aux;
    if (zhi) m[23] = 1'b1;
    return m;
  endfunction

  function automatic exp_t idle();
    exp_t e;
    e.wr = 0; e.idx = 0; e.data = 0; e.done = 0; e.vl = 0; e.ill = 0;
    return e;
  endfunction

  // behavioural model of one run, one entry per cycle from the first slot
  task automatic model();
    int sel = int'(mode_i[20:19]);
    int vlc = (vl_i > 16) ? 16 : int'(vl_i);
    bit zero, snz, vli, inv;
    int crbit = int'(mode_i[23:22]);
    exp_t e;
    inv  = mode_i[21];
    snz  = (sel == 3) ? mode_i[5] : 1'b0;
    vli  = (sel == 1) ? mode_i[5] : 1'b0;
    zero = (sel == 0) ? mode_i[23] : (sel == 1) ? mode_i[4] : (bit_op_i ? mode_i[23] : mode_i[4]);
    q.delete();
    if (sel == 2) begin
      e = idle(); e.done = 1; e.ill = 1; q.push_back(e);
    end else if (vlc == 0) begin
      e = idle(); e.done = 1; q.push_back(e);
    end else begin
      q.push_back(idle());
      for (int i = 0; i < vlc; i++) begin
        bit m = mask_i[i];
        logic [3:0] r = res_i[4*i +: 4];
        logic [3:0] v;
        bit tt, pass, fail;
        fail = 0;
        if (m) v = bit_op_i ? {3'b000, r[0]} : r;
        else   v = bit_op_i ? {3'b000, snz} : {4{snz}};
        tt   = bit_op_i ? v[0] : v[crbit];
        pass = (tt == inv);
        e = idle(); e.idx = i; e.data = v;
        if (m || zero) begin
          if (sel == 0) e.wr = 1;
          else if (sel == 3) e.wr = pass;
          else if (pass) e.wr = 1;
          else begin e.wr = vli; fail = 1; end
        end
        if (fail) begin
          e.done = 1; e.vl = vli ? i + 1 : i;
          q.push_back(e);
          break;
        end
        if (i == vlc - 1) begin e.done = 1; e.vl = vlc; end
        q.push_back(e);
      end
    end
    q.push_back(idle());
    q.push_back(idle());
  endtask

  task automatic cmp(string tag, exp_t e);
    bit ok;
    ok = (wr_o == e.wr) && (done_o == e.done) && (illegal_o == e.ill) &&
         (!e.wr || (int'(wr_idx_o) == e.idx && wr_data_o == e.data)) &&
         (!e.done || int'(vl_o) == e.vl);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got wr=%0b idx=%0d data=%h done=%0b vl=%0d ill=%0b exp wr=%0b idx=%0d data=%h done=%0b vl=%0d ill=%0b",
               tag, wr_o, wr_idx_o, wr_data_o, done_o, vl_o, illegal_o,
               e.wr, e.idx, e.data, e.done, e.vl, e.ill);
    end
  endtask

  // inputs set at a falling edge; poke=1 issues a stray start mid-run
  task automatic run(string tag, logic [23:0] md, bit bop, int vl, logic [15:0] mk_, logic [63:0] rs, bit poke);
    mode_i = md; bit_op_i = bop; vl_i = 5'(vl); mask_i = mk_; res_i = rs;
    model();
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < q.size(); k++) begin
      cmp(tag, q[k]);
      if (poke && k == 1) begin
        start_i = 1'b1; vl_i = 5'd2; mask_i = '0; res_i = '1; mode_i = mk(2, 0, 0, 0, 0, 0);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (wr_o || done_o || illegal_o || busy_o || vl_o != 0) begin
      errors++;
      $display("FAIL R1 reset: wr=%0b done=%0b ill=%0b busy=%0b vl=%0d exp all 0",
               wr_o, done_o, illegal_o, busy_o, vl_o);
    end
    // normal, all elements active
    run("R1 R3", mk(0, 0, 0, 0, 0, 0), 0, 5, 16'hFFFF, 64'h0000_0000_000F_A531, 0);
    // normal, masked elements skipped
    run("R4", mk(0, 0, 0, 0, 0, 0), 0, 5, 16'b10101, 64'h0000_0000_0007_7777, 0);
    // normal, masked elements zeroed
    run("R5", mk(0, 0, 0, 0, 0, 1), 0, 5, 16'b00110, 64'h0000_0000_000F_FFFF, 0);
    // predicate-result, field mode, bit 2 tested against 1, substitute 1
    run("R7", mk(3, 1, 2, 1, 1, 0), 0, 8, 16'h00B7, 64'h0000_0000_8421_C3E5, 0);
    // predicate-result, substitute 0 fails the test; field decode check
    run("R2", mk(3, 1, 1, 1, 0, 0), 0, 6, 16'h0029, 64'h0000_0000_0022_2222, 0);
    // predicate-result, single-bit mode, inv 0, substitute 1 zeroing on bit 23
    run("R6", mk(3, 0, 0, 0, 1, 1), 1, 6, 16'h0015, 64'h0000_0000_00EF_EFEE, 0);
    // fail-first field mode, bit 1 tested, failing element excluded
    run("R8", mk(1, 0, 1, 0, 0, 0), 0, 10, 16'hFFFF, 64'h0000_0011_1114_2841, 0);
    // fail-first single-bit, failing element included, masked skipped untested
    run("R9", mk(1, 1, 0, 0, 1, 0), 1, 10, 16'hFFF5, 64'h0000_0011_1101_0101, 0);
    // fail-first single-bit, failing element excluded, zeroed masked element fails
    run("R9", mk(1, 1, 0, 1, 0, 0), 1, 6, 16'h003B, 64'h0000_0000_0011_1111, 0);
    // fail-first with no failure
    run("R10", mk(1, 0, 3, 0, 0, 0), 0, 4, 16'hFFFF, 64'h0000_0000_0000_1234, 0);
    // zero length
    run("R10", mk(0, 0, 0, 0, 0, 0), 0, 0, 16'hFFFF, 64'h1111_1111_1111_1111, 0);
    // length clamped
    run("R10", mk(0, 0, 0, 0, 0, 0), 0, 20, 16'hFFFF, 64'hFEDC_BA98_7654_3210, 0);
    // reserved selector
    run("R11", mk(2, 1, 3, 1, 1, 1), 0, 5, 16'hFFFF, 64'h0000_0000_000F_FFFF, 0);
    // stray start mid-run
    run("R12", mk(3, 0, 3, 1, 0, 0), 0, 7, 16'h005F, 64'h0000_0000_0F7F_8F0F, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule